// File: doc/BRIEF.md
# Parallel Flash Command Sequencer

This block is the command front end of a parallel NOR-style flash model. Bus write cycles carry an opcode in the low byte of a 16-bit data word. The block decodes them into buffered programs, single-location programs, block erases, block lock set and clear, status reads and clears, and a suspend and resume of a running operation. A small register file stands in for the flash array. A per-block lock bit vector guards it. A fixed cycle counter models the internal program and erase time, and `busy_o` is high while it runs.

A buffered program is four phases long. The first is a setup write. The next is a count write carrying n. Exactly n+1 data writes follow, each with an address and a value. The last is a confirm write. The engine starts only on a correct confirm. After the timer expires, the engine drains its buffer into the array one entry per cycle. Reads return array data, the status byte or a buffer-ready flag, depending on the last read-mode command. While the engine runs, reads return only a cleared ready bit.

Top module: `flash_cmd_seq`

## Requirements
- R1: A write of E8h starts a buffered program. The next write carries n in bits 7:0, and the following n+1 writes store address/data pairs. A write of D0h then starts the engine, and the n+1 entries land in the array in order once the engine finishes.
- R2: The count n may be at most 1Fh in byte mode and at most 0Fh in word mode. A larger count sets the sequence error bit (status bit 5), ends the sequence and starts nothing.
- R3: In a buffered program, any value other than D0h in the confirm position aborts the sequence. This sets status bit 5, leaves the array unchanged and does not raise `busy_o`.
- R4: Both 40h and 10h set up a single program. The next write programs its data at its address.
- R5: A program, erase or buffered program that touches a locked block sets the lock error bit (status bit 4), never raises `busy_o` and leaves the array unchanged.
- R6: Opcodes are decoded from data bits 7:0 only, and bits 15:8 of a command write are ignored.
- R7: While the engine runs and is not suspended, `busy_o` is 1 and `rdata_o` reads 0000h, with bit 7 (ready) low. The status byte is {ready, suspended, sequence error, lock error, 4'b0}.
- R8: B0h written while an operation runs suspends it. `busy_o` drops, status bit 6 is set and the array is not updated. A later D0h resumes the operation, which then completes.
- R9: 60h followed by 01h locks the block addressed. 60h followed by D0h clears all lock bits at once.
- R10: After the E8h setup write, reads return 0080h (buffer available) until the confirm position.
- R11: A write of 50h in the idle state clears status bits 5 and 4.
- R12: 20h followed by D0h erases the addressed block: every word becomes FFFFh.
- R13: In byte mode, programs change only bits 7:0 of a word, and array reads return bits 7:0 with the upper byte zero.
- R14: After reset the array holds FFFFh everywhere, no block is locked, reads come from the array and the status byte is 80h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Bus write strobe, one cycle per write |
| addr_i | input | ADDR_W | Word address for writes and reads |
| wdata_i | input | 16 | Write data: opcode in 7:0, or program data |
| byte_mode_i | input | 1 | 1 selects byte mode, 0 selects word mode |
| rdata_o | output | 16 | Read data for the current read mode |
| busy_o | output | 1 | Engine running and not suspended |
| status_o | output | 8 | Status byte |
| lock_o | output | 2**(ADDR_W-BLK_W) | Per-block lock bits |

## Verification
If the sequencer state is wrong, it shows on the next bus cycle. A miscounted data phase changes the cycle on which `status_o` reports an abort or on which `busy_o` rises after the confirm. A wrong lock decision shows at once as a missing lock error bit. It also shows, once the engine has finished, as changed array words in a read-back against the bench's model. A suspend that fails to stop the engine shows as array data changing during the suspended window, which is read back before the resume.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
  localparam logic [7:0] OP_RD_ARRAY  = 8'hFF;
  localparam logic [7:0] OP_RD_STATUS = 8'h70;
  localparam logic [7:0] OP_CLR_STAT  = 8'h50;
  localparam logic [7:0] OP_BUF_SETUP = 8'hE8;
  localparam logic [7:0] OP_PGM_A     = 8'h40;
  localparam logic [7:0] OP_PGM_B     = 8'h10;
  localparam logic [7:0] OP_ERASE     = 8'h20;
  localparam logic [7:0] OP_CONFIRM   = 8'hD0;
  localparam logic [7:0] OP_SUSPEND   = 8'hB0;
  localparam logic [7:0] OP_LOCK_SET  = 8'h60;
  localparam logic [7:0] OP_LOCK_ONE  = 8'h01;

  typedef enum logic [3:0] {
    S_IDLE, S_BUF_CNT, S_BUF_DATA, S_BUF_CONF, S_PGM_DATA,
    S_ERS_CONF, S_LOCK_CONF, S_RUN, S_DRAIN
  } seq_state_e;

  typedef enum logic [1:0] {RM_ARRAY, RM_STATUS, RM_BUFAV} rd_mode_e;
endpackage

// File: rtl/flash_busy_timer.sv
module flash_busy_timer #(
  parameter int CYC = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic run_i,
  output logic done_o
);
  localparam int CW = $clog2(CYC + 1);
  logic [CW-1:0] cnt_q;

  assign done_o = run_i && (cnt_q == CW'(CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (run_i)  cnt_q <= cnt_q + CW'(1);
  end
endmodule

// File: rtl/flash_lock_bits.sv
module flash_lock_bits #(
  parameter int NBLK  = 4,
  parameter int IDX_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_i,
  input  logic             clr_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [NBLK-1:0]  lock_o
);
  for (genvar b = 0; b < NBLK; b++) begin : g_blk
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              lock_o[b] <= 1'b0;
      else if (clr_i)                           lock_o[b] <= 1'b0;
      else if (set_i && idx_i == IDX_W'(b))     lock_o[b] <= 1'b1;
    end
  end
endmodule

// File: rtl/flash_store.sv
module flash_store #(
  parameter int ADDR_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [15:0]       wdata_i,
  input  logic [1:0]        wmask_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [15:0]       rdata_o
);
  localparam int WORDS = 1 << ADDR_W;
  logic [15:0] mem_q [WORDS];

  assign rdata_o = mem_q[raddr_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < WORDS; i++) mem_q[i] <= 16'hFFFF;
    end else if (we_i) begin
      for (int l = 0; l < 2; l++)
        if (wmask_i[l]) mem_q[waddr_i][l*8 +: 8] <= wdata_i[l*8 +: 8];
    end
  end
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W       = 5,
  parameter int BLK_W        = 3,
  parameter int BUSY_CYC     = 8,
  parameter int CNT_MAX_BYTE = 31,
  parameter int CNT_MAX_WORD = 15
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                wr_en_i,
  input  logic [ADDR_W-1:0]                   addr_i,
  input  logic [15:0]                         wdata_i,
  input  logic                                byte_mode_i,
  output logic [15:0]                         rdata_o,
  output logic                                busy_o,
  output logic [7:0]                          status_o,
  output logic [(1<<(ADDR_W-BLK_W))-1:0]      lock_o
);
  localparam int BI_W      = ADDR_W - BLK_W;
  localparam int NBLK      = 1 << BI_W;
  localparam int BLK_WORDS = 1 << BLK_W;
  localparam int BUF_D     = CNT_MAX_BYTE + 1;
  localparam int IDX_W     = $clog2(BUF_D);

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [15:0]       data;
  } buf_ent_t;

  seq_state_e state_q, state_d;
  rd_mode_e   rmode_q, rmode_d;
  logic susp_q, susp_d, seq_err_q, seq_err_d, lock_err_q, lock_err_d;
  logic erase_q, erase_d, bm_q, bm_d, hit_q, hit_d;
  logic [IDX_W-1:0] cnt_q, cnt_d, idx_q, idx_d, last_idx;
  logic [BI_W-1:0]  eblk_q, eblk_d;
  buf_ent_t buf_q [BUF_D];
  logic buf_we;
  logic [IDX_W-1:0] buf_widx;

  logic [7:0]       op;
  logic [BI_W-1:0]  wr_blk;
  logic             wr_locked, eng_run, tmr_done;
  logic             lk_set, lk_clr;
  logic             st_we;
  logic [ADDR_W-1:0] st_waddr;
  logic [15:0]      st_wdata, st_rdata;
  logic [1:0]       st_wmask;
  int               cnt_lim;

  assign op        = wdata_i[7:0];  // upper byte never decoded
  assign wr_blk    = addr_i[ADDR_W-1:BLK_W];
  assign wr_locked = lock_o[wr_blk];
  assign cnt_lim   = byte_mode_i ? CNT_MAX_BYTE : CNT_MAX_WORD;
  assign eng_run   = (state_q == S_RUN) || (state_q == S_DRAIN);
  assign busy_o    = eng_run && !susp_q;
  assign status_o  = {!busy_o, susp_q, seq_err_q, lock_err_q, 4'b0000};
  assign last_idx  = erase_q ? IDX_W'(BLK_WORDS - 1) : cnt_q;

  flash_busy_timer #(.CYC(BUSY_CYC)) u_timer (
    .clk_i, .rst_ni,
    .clr_i (state_q != S_RUN),
    .run_i (state_q == S_RUN && !susp_q),
    .done_o(tmr_done)
  );

  flash_lock_bits #(.NBLK(NBLK), .IDX_W(BI_W)) u_locks (
    .clk_i, .rst_ni, .set_i(lk_set), .clr_i(lk_clr), .idx_i(wr_blk), .lock_o
  );

  assign st_we    = (state_q == S_DRAIN) && !susp_q;
  assign st_waddr = erase_q ? {eblk_q, idx_q[BLK_W-1:0]} : buf_q[idx_q].addr;
  assign st_wdata = erase_q ? 16'hFFFF : buf_q[idx_q].data;
  assign st_wmask = (bm_q && !erase_q) ? 2'b01 : 2'b11;

  flash_store #(.ADDR_W(ADDR_W)) u_store (
    .clk_i, .rst_ni, .we_i(st_we), .waddr_i(st_waddr), .wdata_i(st_wdata),
    .wmask_i(st_wmask), .raddr_i(addr_i), .rdata_o(st_rdata)
  );

  always_ff @(posedge clk_i) begin
    if (buf_we) buf_q[buf_widx] <= '{addr: addr_i, data: wdata_i};
  end

  always_comb begin
    state_d = state_q;  rmode_d = rmode_q;  susp_d = susp_q;
    seq_err_d = seq_err_q;  lock_err_d = lock_err_q;
    erase_d = erase_q;  bm_d = bm_q;  hit_d = hit_q;
    cnt_d = cnt_q;  idx_d = idx_q;  eblk_d = eblk_q;
    buf_we = 1'b0;  buf_widx = idx_q;  lk_set = 1'b0;  lk_clr = 1'b0;
    unique case (state_q)
      S_IDLE: if (wr_en_i) begin
        unique case (op)
          OP_RD_ARRAY:  rmode_d = RM_ARRAY;
          OP_RD_STATUS: rmode_d = RM_STATUS;
          OP_CLR_STAT:  begin seq_err_d = 1'b0; lock_err_d = 1'b0; end
          OP_BUF_SETUP: begin state_d = S_BUF_CNT;   rmode_d = RM_BUFAV;  end
          OP_PGM_A,
          OP_PGM_B:     begin state_d = S_PGM_DATA;  rmode_d = RM_STATUS; end
          OP_ERASE:     begin state_d = S_ERS_CONF;  rmode_d = RM_STATUS; end
          OP_LOCK_SET:  begin state_d = S_LOCK_CONF; rmode_d = RM_STATUS; end
          default: ;
        endcase
      end
      S_BUF_CNT: if (wr_en_i) begin
        if (int'(op) > cnt_lim) begin
          seq_err_d = 1'b1; state_d = S_IDLE; rmode_d = RM_STATUS;
        end else begin
          cnt_d = op[IDX_W-1:0]; idx_d = '0; hit_d = 1'b0;
          bm_d = byte_mode_i; state_d = S_BUF_DATA;
        end
      end
      S_BUF_DATA: if (wr_en_i) begin
        buf_we = 1'b1;
        hit_d  = hit_q | wr_locked;
        if (idx_q == cnt_q) state_d = S_BUF_CONF;
        else                idx_d   = idx_q + IDX_W'(1);
      end
      S_BUF_CONF: if (wr_en_i) begin
        rmode_d = RM_STATUS; state_d = S_IDLE;
        if (op != OP_CONFIRM) seq_err_d = 1'b1;
        else if (hit_q)       lock_err_d = 1'b1;
        else begin state_d = S_RUN; erase_d = 1'b0; idx_d = '0; end
      end
      S_PGM_DATA: if (wr_en_i) begin
        rmode_d = RM_STATUS; buf_we = 1'b1; buf_widx = '0;
        if (wr_locked) begin lock_err_d = 1'b1; state_d = S_IDLE; end
        else begin
          state_d = S_RUN; erase_d = 1'b0; cnt_d = '0; idx_d = '0; bm_d = byte_mode_i;
        end
      end
      S_ERS_CONF: if (wr_en_i) begin
        rmode_d = RM_STATUS; state_d = S_IDLE;
        if (op != OP_CONFIRM) seq_err_d = 1'b1;
        else if (wr_locked)   lock_err_d = 1'b1;
        else begin state_d = S_RUN; erase_d = 1'b1; eblk_d = wr_blk; idx_d = '0; end
      end
      S_LOCK_CONF: if (wr_en_i) begin
        state_d = S_IDLE;
        if (op == OP_LOCK_ONE)     lk_set = 1'b1;
        else if (op == OP_CONFIRM) lk_clr = 1'b1;
        else                       seq_err_d = 1'b1;
      end
      S_RUN, S_DRAIN: begin
        if (wr_en_i) begin
          if (susp_q) begin
            if (op == OP_CONFIRM)        begin susp_d = 1'b0; rmode_d = RM_STATUS; end
            else if (op == OP_RD_ARRAY)  rmode_d = RM_ARRAY;
            else if (op == OP_RD_STATUS) rmode_d = RM_STATUS;
          end else if (op == OP_SUSPEND) begin
            susp_d = 1'b1; rmode_d = RM_STATUS;
          end
        end
        if (state_q == S_RUN && tmr_done) begin
          state_d = S_DRAIN; idx_d = '0;
        end else if (state_q == S_DRAIN && !susp_q) begin
          if (idx_q == last_idx) begin state_d = S_IDLE; susp_d = 1'b0; end
          else idx_d = idx_q + IDX_W'(1);
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;  rmode_q <= RM_ARRAY;  susp_q <= 1'b0;
      seq_err_q <= 1'b0;  lock_err_q <= 1'b0;  erase_q <= 1'b0;
      bm_q <= 1'b0;  hit_q <= 1'b0;  cnt_q <= '0;  idx_q <= '0;  eblk_q <= '0;
    end else begin
      state_q <= state_d;  rmode_q <= rmode_d;  susp_q <= susp_d;
      seq_err_q <= seq_err_d;  lock_err_q <= lock_err_d;  erase_q <= erase_d;
      bm_q <= bm_d;  hit_q <= hit_d;  cnt_q <= cnt_d;  idx_q <= idx_d;  eblk_q <= eblk_d;
    end
  end

  always_comb begin
    if (busy_o) rdata_o = 16'h0000;
    else begin
      unique case (rmode_q)
        RM_ARRAY:  rdata_o = byte_mode_i ? {8'h00, st_rdata[7:0]} : st_rdata;
        RM_STATUS: rdata_o = {8'h00, status_o};
        default:   rdata_o = 16'h0080;
      endcase
    end
  end
endmodule

// File: rtl/flash_cmd_seq_chk.sv
module flash_cmd_seq_chk
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W       = 5,
  parameter int BLK_W        = 3,
  parameter int CNT_MAX_BYTE = 31,
  parameter int CNT_MAX_WORD = 15
) (
  input logic                           clk_i,
  input logic                           rst_ni,
  input logic                           wr_en_i,
  input logic [ADDR_W-1:0]              addr_i,
  input logic [15:0]                    wdata_i,
  input logic                           byte_mode_i,
  input logic [15:0]                    rdata_o,
  input logic                           busy_o,
  input logic [7:0]                     status_o,
  input logic [(1<<(ADDR_W-BLK_W))-1:0] lock_o,
  input seq_state_e                     state_i,
  input logic                           st_we_i,
  input logic [ADDR_W-1:0]              st_waddr_i
);
  logic [7:0] op;
  assign op = wdata_i[7:0];

  // R7
  busy_read_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (rdata_o == 16'h0000 && !status_o[7]));

  // R5
  no_locked_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_we_i |-> !lock_o[st_waddr_i[ADDR_W-1:BLK_W]]);

  // R3
  confirm_abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && state_i == S_BUF_CONF && op != OP_CONFIRM) |=> (status_o[5] && !busy_o));

  // R2
  count_limit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && state_i == S_BUF_CNT &&
     int'(op) > (byte_mode_i ? CNT_MAX_BYTE : CNT_MAX_WORD)) |=> (status_o[5] && state_i == S_IDLE));

  // R9
  clear_all_locks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && state_i == S_LOCK_CONF && op == OP_CONFIRM) |=> (lock_o == '0));

  // R11
  clear_status_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && state_i == S_IDLE && op == OP_CLR_STAT) |=> (status_o[5:4] == 2'b00));

  // R8
  suspend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && state_i == S_RUN && busy_o && op == OP_SUSPEND) |=> (!busy_o && status_o[6]));

  // R10
  buf_avail_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && state_i == S_IDLE && op == OP_BUF_SETUP) |=> (rdata_o == 16'h0080));

  // R4
  single_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && state_i == S_PGM_DATA && !lock_o[addr_i[ADDR_W-1:BLK_W]]) |=> busy_o);
endmodule

bind flash_cmd_seq flash_cmd_seq_chk #(
  .ADDR_W(ADDR_W), .BLK_W(BLK_W), .CNT_MAX_BYTE(CNT_MAX_BYTE), .CNT_MAX_WORD(CNT_MAX_WORD)
) u_chk (
  .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i, .byte_mode_i, .rdata_o, .busy_o,
  .status_o, .lock_o, .state_i(state_q), .st_we_i(st_we), .st_waddr_i(st_waddr)
);

// File: tb/flash_cmd_seq_bench.sv
module flash_cmd_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic        byte_mode = 1'b0;
  logic [15:0] rdata;
  logic        busy;
  logic [7:0]  status;
  logic [3:0]  lock;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;
  logic [15:0] em [32];

  always #10 clk = ~clk;  // 50 MHz

  flash_cmd_seq u_flash_cmd_seq (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .byte_mode_i(byte_mode), .rdata_o(rdata), .busy_o(busy), .status_o(status), .lock_o(lock)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic wait_idle();
    for (int n = 0; n < 400 && busy; n++) @(negedge clk);
  endtask

  function automatic logic [15:0] merge(input logic [15:0] old, input logic [15:0] d, input bit bm);
    return bm ? {old[15:8], d[7:0]} : d;
  endfunction

  task automatic verify_mem(input string req);
    logic [15:0] v;
    byte_mode = 1'b0;
    wr(5'd0, 16'h00FF);
    for (int i = 0; i < 32; i++) begin
      rd(5'(i), v);
      check(req, {16'h0, v}, {16'h0, em[i]});
    end
  endtask

  task automatic buf_prog(input int n, input logic [4:0] base, input bit bm);
    logic [15:0] d;
    byte_mode = bm;
    wr(base, 16'h00E8);
    wr(base, 16'(n));
    for (int i = 0; i <= n; i++) begin
      d = 16'($urandom);
      em[5'(base + i)] = merge(em[5'(base + i)], d, bm);
      wr(5'(base + i), d);
    end
    wr(base, 16'h00D0);
    wait_idle();
    byte_mode = 1'b0;
  endtask

  task automatic single_prog(input logic [4:0] a, input logic [15:0] d, input logic [15:0] opw, input bit bm);
    byte_mode = bm;
    wr(a, opw);
    em[a] = merge(em[a], d, bm);
    wr(a, d);
    wait_idle();
    byte_mode = 1'b0;
  endtask

  task automatic erase_blk(input logic [4:0] a);
    wr(a, 16'h0020);
    wr(a, 16'h00D0);
    for (int i = 0; i < 8; i++) em[{a[4:3], 3'(i)}] = 16'hFFFF;
    wait_idle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    logic [15:0] d0, d1;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 32; i++) em[i] = 16'hFFFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R14 reset state
    rd(5'd0, v);
    check("R14 array after reset", {16'h0, v}, 32'h0000FFFF);
    check("R14 status after reset", {24'h0, status}, 32'h80);
    check("R14 locks after reset", {28'h0, lock}, 32'h0);
    check("R14 busy after reset", {31'h0, busy}, 32'h0);

    // R10 then R1 buffered program, n=2
    wr(5'd1, 16'h00E8);
    rd(5'd1, v);
    check("R10 buffer available", {16'h0, v}, 32'h0080);
    wr(5'd1, 16'h0002);
    rd(5'd1, v);
    check("R10 after count", {16'h0, v}, 32'h0080);
    for (int i = 1; i <= 3; i++) begin
      d0 = 16'h1000 + 16'(i * 16'h0111);
      em[i] = d0;
      wr(5'(i), d0);
    end
    wr(5'd1, 16'h00D0);
    check("R7 busy after confirm", {31'h0, busy}, 32'h1);
    check("R7 read while busy", {16'h0, rdata}, 32'h0);
    check("R7 status while busy", {24'h0, status}, 32'h00);
    wait_idle();
    check("R7 status when done", {24'h0, status}, 32'h80);
    verify_mem("R1 buffered program");

    // R4 and R6: both setup opcodes, upper byte ignored
    single_prog(5'd9, 16'hBEEF, 16'h7F40, 1'b0);
    single_prog(5'd10, 16'hCAFE, 16'h5510, 1'b0);
    wr(5'd0, 16'hA570);
    rd(5'd0, v);
    check("R6 status read with upper byte set", {16'h0, v}, 32'h0080);
    verify_mem("R4 single program 40h/10h");

    // R3 abort then R11 clear
    wr(5'd2, 16'h00E8);
    wr(5'd2, 16'h0001);
    wr(5'd2, 16'hAAAA);
    wr(5'd3, 16'hBBBB);
    wr(5'd2, 16'h00FF);
    check("R3 abort status", {24'h0, status}, 32'hA0);
    check("R3 abort not busy", {31'h0, busy}, 32'h0);
    wr(5'd0, 16'h0050);
    check("R11 clear status", {24'h0, status}, 32'h80);
    verify_mem("R3 array unchanged after abort");

    // R2 count limits
    wr(5'd0, 16'h00E8);
    wr(5'd0, 16'h0010);
    check("R2 word count 10h rejected", {24'h0, status}, 32'hA0);
    wr(5'd0, 16'h0050);
    byte_mode = 1'b1;
    wr(5'd0, 16'h00E8);
    wr(5'd0, 16'h0020);
    check("R2 byte count 20h rejected", {24'h0, status}, 32'hA0);
    wr(5'd0, 16'h0050);
    buf_prog(31, 5'd0, 1'b1);
    check("R2 byte count 1Fh accepted", {24'h0, status}, 32'h80);
    byte_mode = 1'b1;
    wr(5'd0, 16'h00FF);
    rd(5'd9, v);
    check("R13 byte mode read", {16'h0, v}, {24'h0, em[9][7:0]});
    byte_mode = 1'b0;
    verify_mem("R13 upper byte kept in byte mode");
    buf_prog(15, 5'd8, 1'b0);
    check("R2 word count 0Fh accepted", {24'h0, status}, 32'h80);

    // R9 and R5 locks
    wr(5'd16, 16'h0060);
    wr(5'd16, 16'h0001);
    check("R9 lock block 2", {28'h0, lock}, 32'h4);
    wr(5'd17, 16'h0040);
    wr(5'd17, 16'h1234);
    check("R5 program locked status", {24'h0, status}, 32'h90);
    check("R5 program locked not busy", {31'h0, busy}, 32'h0);
    wr(5'd0, 16'h0050);
    wr(5'd18, 16'h0020);
    wr(5'd18, 16'h00D0);
    check("R5 erase locked status", {24'h0, status}, 32'h90);
    wr(5'd0, 16'h0050);
    wr(5'd0, 16'h00E8);
    wr(5'd0, 16'h0001);
    wr(5'd5, 16'h5555);
    wr(5'd20, 16'h2020);
    wr(5'd0, 16'h00D0);
    check("R5 buffered locked status", {24'h0, status}, 32'h90);
    check("R5 buffered locked not busy", {31'h0, busy}, 32'h0);
    wr(5'd0, 16'h0050);
    verify_mem("R5 array unchanged on lock fault");
    wr(5'd0, 16'h0060);
    wr(5'd0, 16'h0001);
    wr(5'd24, 16'h0060);
    wr(5'd24, 16'h0001);
    check("R9 lock blocks 0,2,3", {28'h0, lock}, 32'hD);
    wr(5'd8, 16'h0060);
    wr(5'd8, 16'h00D0);
    check("R9 clear all locks", {28'h0, lock}, 32'h0);

    // R12 erase
    erase_blk(5'd3);
    verify_mem("R12 block erase");

    // R8 suspend and resume
    d0 = 16'h7A7A; d1 = 16'h3C3C;
    wr(5'd24, 16'h00E8);
    wr(5'd24, 16'h0001);
    wr(5'd24, d0);
    wr(5'd25, d1);
    wr(5'd24, 16'h00D0);
    check("R7 busy on buffered start", {31'h0, busy}, 32'h1);
    wr(5'd0, 16'h00B0);
    check("R8 suspend drops busy", {31'h0, busy}, 32'h0);
    check("R8 suspend status", {24'h0, status}, 32'hC0);
    wr(5'd0, 16'h00FF);
    repeat (20) @(negedge clk);
    rd(5'd24, v);
    check("R8 array held while suspended", {16'h0, v}, {16'h0, em[24]});
    rd(5'd25, v);
    check("R8 array held while suspended", {16'h0, v}, {16'h0, em[25]});
    wr(5'd0, 16'h00D0);
    check("R8 resume raises busy", {31'h0, busy}, 32'h1);
    em[24] = d0; em[25] = d1;
    wait_idle();
    check("R8 status after resume", {24'h0, status}, 32'h80);
    verify_mem("R8 completes after resume");

    // Random mix of R1, R4, R12, R13
    for (int it = 0; it < 24; it++) begin
      int kind;
      bit bm;
      logic [4:0] a;
      kind = int'($urandom % 3);
      bm = 1'($urandom % 2);
      a = 5'($urandom);
      if (kind == 0) buf_prog(int'($urandom % (bm ? 32 : 16)), a, bm);
      else if (kind == 1) single_prog(a, 16'($urandom), ($urandom % 2) ? 16'h0040 : 16'h0010, bm);
      else erase_blk(a);
    end
    verify_mem("R1 R4 R12 R13 random mix");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule